// File: doc/BRIEF.md
# Conversion Timing Sequencer for a Successive-Approximation ADC

This block is the digital timing engine that sits in front of a successive-approximation converter core. It holds two channel lists, a regular list and an injected list. On a start request it walks the chosen list once, in list order. For each entry it runs a sampling phase whose length comes from a 3-bit code owned by that channel. A fixed conversion phase follows, and then the result is stored and status flags are raised. The analog core is replaced by a combinational stub that supplies a result word at the end of the conversion phase.

The block counts in half ADC-clock units. Its clock `clk` is a reference at twice the ADC clock, so one `clk` cycle is half an ADC clock. Sampling lengths of the form N.5 cycles therefore become whole tick counts. A sequence can start from a software start pulse or from an external trigger that has its own enable. Either way there is one input pair per group. While a list runs, its start bit reads back as 1. The start bit clears by itself when the last entry has been converted.

Top module: `adc_seq_timer`

## Requirements
- R1: Each channel `c` takes its sampling code from `smp_code[3c +: 3]`. A channel number at or above NCH uses code 0. Codes 0 to 7 give 2.5, 6.5, 12.5, 24.5, 47.5, 92.5, 247.5 and 640.5 ADC cycles, which is 5, 13, 25, 49, 95, 185, 495 and 1281 `clk` ticks. For the first entry of a regular list, flag bit 0 (end of sampling) is set exactly that many rising edges after the edge that accepts the start.
- R2: A fixed conversion phase of 12.5 ADC cycles (25 ticks) follows each sampling phase. The end-of-conversion flag for an entry is therefore set 2×(sampling + 12.5) ticks after its sampling phase began, which is 30 ticks for code 0.
- R3: The end-of-sampling flag (bit 0) is raised only by regular-list entries, never by injected ones.
- R4: One start converts each entry of the selected list exactly once, from entry 0 up to entry `len`, and then stops. The list has entry `i` at bits `[i*CH_W +: CH_W]`, and the length input holds the entry count minus one.
- R5: A regular list starts on a `reg_sw_start` pulse, or on a rising edge of `reg_trig` while `reg_trig_en` is 1. The injected list starts in the same way from `inj_sw_start`, `inj_trig` and `inj_trig_en`. If both groups request a start in the same cycle, the injected group wins.
- R6: A start request of either group that arrives while any list is running is ignored and does not start a sequence afterwards.
- R7: At the end of each conversion, the stub result, the low DATA_W bits of `(ch × 0x0421) XOR 0x5A00`, is written to `reg_data` for a regular entry or to `inj_data` for an injected entry. The other register keeps its value.
- R8: The flags are bit 0 end of sampling, bit 1 regular end of conversion and bit 2 injected end of conversion. Each flag stays set until a 1 is written to the same bit of `flag_clr`. A set event and a clear in the same cycle leave the flag set.
- R9: `irq` is 1 exactly when some flag bit is set and the same bit of `irq_en` is 1.
- R10: `reg_start_bit` or `inj_start_bit` reads 1 from the cycle after the accepting edge until the edge that completes the last entry of that list.
- R11: An external trigger has no effect while its enable is 0. A trigger held high starts only one sequence.
- R12: After reset, the flags, both start bits, `irq`, `reg_data` and `inj_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-ADC-rate reference clock (one tick = half ADC cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_code | input | 3*NCH | Per-channel sampling codes |
| reg_list | input | REG_DEPTH*CH_W | Regular channel list |
| reg_len | input | clog2(REG_DEPTH) | Regular entry count minus one |
| inj_list | input | INJ_DEPTH*CH_W | Injected channel list |
| inj_len | input | clog2(INJ_DEPTH) | Injected entry count minus one |
| reg_sw_start | input | 1 | Software start pulse, regular list |
| inj_sw_start | input | 1 | Software start pulse, injected list |
| reg_trig | input | 1 | External trigger, regular list |
| inj_trig | input | 1 | External trigger, injected list |
| reg_trig_en | input | 1 | Enable for reg_trig |
| inj_trig_en | input | 1 | Enable for inj_trig |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| irq_en | input | 3 | Per-flag interrupt enable |
| reg_start_bit | output | 1 | Regular list running |
| inj_start_bit | output | 1 | Injected list running |
| flags | output | 3 | Sticky status flags |
| irq | output | 1 | Interrupt request |
| reg_data | output | DATA_W | Last regular result |
| inj_data | output | DATA_W | Last injected result |

## Verification
The bench builds the block with NCH=8, REG_DEPTH=4, INJ_DEPTH=2, CH_W=5, DATA_W=16 and edge-sensitive triggers. With a 4-entry regular list, a run from entry 0 to the top index takes about 120 ticks, so the full walk and the stop that follows it are observed. With a 2-entry injected list, the one-bit length field is driven to its maximum. Because the regular list is small, all eight sampling codes, including the 1281-tick code, can each be measured on a single-entry list in a few thousand cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAMP = 2'd1,
      PH_CONV = 2'd2
   } phase_e;

   localparam int NFLG     = 3;
   localparam int FLG_SMP  = 0;
   localparam int FLG_REOC = 1;
   localparam int FLG_JEOC = 2;

   // conversion phase in half ADC cycles (12.5 cycles)
   localparam int CONV_HALF     = 25;
   localparam int SMP_HALF_MAX  = 1281;
   localparam int TMR_W         = $clog2(SMP_HALF_MAX + 1);

   // sampling length in half ADC cycles for a 3-bit code
   function automatic logic [TMR_W-1:0] smp_half(input logic [2:0] code);
      logic [TMR_W-1:0] t;
      case (code)
         3'd0:    t = TMR_W'(5);
         3'd1:    t = TMR_W'(13);
         3'd2:    t = TMR_W'(25);
         3'd3:    t = TMR_W'(49);
         3'd4:    t = TMR_W'(95);
         3'd5:    t = TMR_W'(185);
         3'd6:    t = TMR_W'(495);
         default: t = TMR_W'(1281);
      endcase
      return t;
   endfunction

endpackage

// File: rtl/adc_smp_lut.sv
module adc_smp_lut
   import adc_seq_pkg::*;
#(
   parameter int NCH  = 19,
   parameter int CH_W = 5
) (
   input  logic [3*NCH-1:0]  smp_code,
   input  logic [CH_W-1:0]   ch,
   output logic [TMR_W-1:0]  ticks
);

   logic [TMR_W-1:0] per_ch [NCH];

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         assign per_ch[g] = smp_half(smp_code[3*g +: 3]);
      end
   endgenerate

   always_comb begin
      ticks = smp_half(3'd0);
      for (int k = 0; k < NCH; k++) begin
         if (ch == CH_W'(k)) ticks = per_ch[k];
      end
   end

endmodule

// File: rtl/adc_seq_list.sv
module adc_seq_list #(
   parameter int DEPTH = 16,
   parameter int CH_W  = 5,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [DEPTH*CH_W-1:0] list,
   input  logic [IW-1:0]         idx_a,
   input  logic [IW-1:0]         idx_b,
   output logic [CH_W-1:0]       ch_a,
   output logic [CH_W-1:0]       ch_b
);

   logic [CH_W-1:0] ent [DEPTH];

   generate
      if ((1 << IW) != DEPTH) begin : g_bad_depth
         $error("adc_seq_list: DEPTH must be a power of two");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         assign ent[g] = list[g*CH_W +: CH_W];
      end
   endgenerate

   assign ch_a = ent[idx_a];
   assign ch_b = ent[idx_b];

endmodule

// File: rtl/adc_trig_cond.sv
module adc_trig_cond #(
   parameter bit EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic en,
   output logic req
);

   logic trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig;
   end

   generate
      if (EDGE) begin : g_edge
         assign req = en & trig & ~trig_q;
      end else begin : g_level
         assign req = en & trig_q;
      end
   endgenerate

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
   import adc_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             zero
);

   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R2
   timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

   // R2
   timer_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero);

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
   parameter int CH_W   = 5,
   parameter int DATA_W = 16
) (
   input  logic [CH_W-1:0]   ch,
   output logic [DATA_W-1:0] result
);

   localparam logic [DATA_W-1:0] MUL  = DATA_W'(32'h0421);
   localparam logic [DATA_W-1:0] XORV = DATA_W'(32'h5A00);

   assign result = (DATA_W'(ch) * MUL) ^ XORV;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
   import adc_seq_pkg::*;
#(
   parameter int NCH       = 19,
   parameter int CH_W      = 5,
   parameter int REG_DEPTH = 16,
   parameter int INJ_DEPTH = 4,
   parameter int DATA_W    = 16,
   parameter bit TRIG_EDGE = 1'b1,
   localparam int RL_W     = $clog2(REG_DEPTH),
   localparam int IL_W     = $clog2(INJ_DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [3*NCH-1:0]          smp_code,
   input  logic [REG_DEPTH*CH_W-1:0] reg_list,
   input  logic [RL_W-1:0]           reg_len,
   input  logic [INJ_DEPTH*CH_W-1:0] inj_list,
   input  logic [IL_W-1:0]           inj_len,
   input  logic                      reg_sw_start,
   input  logic                      inj_sw_start,
   input  logic                      reg_trig,
   input  logic                      inj_trig,
   input  logic                      reg_trig_en,
   input  logic                      inj_trig_en,
   input  logic [NFLG-1:0]           flag_clr,
   input  logic [NFLG-1:0]           irq_en,
   output logic                      reg_start_bit,
   output logic                      inj_start_bit,
   output logic [NFLG-1:0]           flags,
   output logic                      irq,
   output logic [DATA_W-1:0]         reg_data,
   output logic [DATA_W-1:0]         inj_data
);

   localparam int IDX_W = (RL_W > IL_W) ? RL_W : IL_W;

   generate
      if (REG_DEPTH < 2 || REG_DEPTH > 16) begin : g_bad_reg
         $error("adc_seq_timer: REG_DEPTH out of range 2..16");
      end
      if (INJ_DEPTH < 2 || INJ_DEPTH > 16) begin : g_bad_inj
         $error("adc_seq_timer: INJ_DEPTH out of range 2..16");
      end
      if (NCH < 1 || NCH > (1 << CH_W)) begin : g_bad_nch
         $error("adc_seq_timer: NCH does not fit CH_W");
      end
      if (DATA_W < CH_W || DATA_W > 32) begin : g_bad_dw
         $error("adc_seq_timer: DATA_W out of range");
      end
   endgenerate

   phase_e            phase;
   logic              grp;          // 1 = injected list
   logic [IDX_W-1:0]  idx;

   logic              reg_trig_req, inj_trig_req;
   logic              reg_req, inj_req;
   logic              idle, acc, acc_grp;
   logic              samp_end, conv_end, last;
   logic              t_zero, t_load;
   logic [TMR_W-1:0]  t_val, ticks_nxt;
   logic              nxt_grp;
   logic [IDX_W-1:0]  nxt_idx;
   logic [CH_W-1:0]   reg_cur, reg_nxt, inj_cur, inj_nxt;
   logic [CH_W-1:0]   cur_ch, nxt_ch;
   logic [DATA_W-1:0] result;
   logic [NFLG-1:0]   set_v;

   // start requests
   adc_trig_cond #(.EDGE(TRIG_EDGE)) u_reg_trig (
      .clk(clk), .rst_n(rst_n), .trig(reg_trig), .en(reg_trig_en), .req(reg_trig_req));

   adc_trig_cond #(.EDGE(TRIG_EDGE)) u_inj_trig (
      .clk(clk), .rst_n(rst_n), .trig(inj_trig), .en(inj_trig_en), .req(inj_trig_req));

   assign reg_req = reg_sw_start | reg_trig_req;
   assign inj_req = inj_sw_start | inj_trig_req;
   assign idle    = (phase == PH_IDLE);
   assign acc     = idle & (reg_req | inj_req);
   assign acc_grp = inj_req;

   // list lookup: current entry and the entry the timer loads next
   assign nxt_grp = idle ? acc_grp : grp;
   assign nxt_idx = idle ? '0 : idx + 1'b1;

   adc_seq_list #(.DEPTH(REG_DEPTH), .CH_W(CH_W)) u_reg_list (
      .list(reg_list), .idx_a(idx[RL_W-1:0]), .idx_b(nxt_idx[RL_W-1:0]),
      .ch_a(reg_cur), .ch_b(reg_nxt));

   adc_seq_list #(.DEPTH(INJ_DEPTH), .CH_W(CH_W)) u_inj_list (
      .list(inj_list), .idx_a(idx[IL_W-1:0]), .idx_b(nxt_idx[IL_W-1:0]),
      .ch_a(inj_cur), .ch_b(inj_nxt));

   assign cur_ch = grp ? inj_cur : reg_cur;
   assign nxt_ch = nxt_grp ? inj_nxt : reg_nxt;

   adc_smp_lut #(.NCH(NCH), .CH_W(CH_W)) u_lut (
      .smp_code(smp_code), .ch(nxt_ch), .ticks(ticks_nxt));

   adc_conv_stub #(.CH_W(CH_W), .DATA_W(DATA_W)) u_stub (
      .ch(cur_ch), .result(result));

   // phase timing
   assign samp_end = (phase == PH_SAMP) & t_zero;
   assign conv_end = (phase == PH_CONV) & t_zero;
   assign last     = grp ? (idx[IL_W-1:0] == inj_len) : (idx[RL_W-1:0] == reg_len);
   assign t_load   = acc | samp_end | (conv_end & ~last);
   assign t_val    = samp_end ? TMR_W'(CONV_HALF - 1) : (ticks_nxt - 1'b1);

   adc_phase_timer u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         grp   <= 1'b0;
         idx   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (acc) begin
               phase <= PH_SAMP;
               grp   <= acc_grp;
               idx   <= '0;
            end
            PH_SAMP: if (t_zero) phase <= PH_CONV;
            PH_CONV: if (t_zero) begin
               if (last) begin
                  phase <= PH_IDLE;
               end else begin
                  phase <= PH_SAMP;
                  idx   <= nxt_idx;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign reg_start_bit = ~idle & ~grp;
   assign inj_start_bit = ~idle &  grp;

   // flags and results
   assign set_v[FLG_SMP]  = samp_end & ~grp;
   assign set_v[FLG_REOC] = conv_end & ~grp;
   assign set_v[FLG_JEOC] = conv_end &  grp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         reg_data <= '0;
         inj_data <= '0;
      end else begin
         flags <= (flags & ~flag_clr) | set_v;
         if (set_v[FLG_REOC]) reg_data <= result;
         if (set_v[FLG_JEOC]) inj_data <= result;
      end
   end

   assign irq = |(flags & irq_en);

   // R3
   smp_flag_reg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FLG_SMP]) |-> $past(reg_start_bit));

   // R6
   reg_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_start_bit && reg_req) |=> !reg_start_bit);

   // R6
   inj_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_start_bit && inj_req) |=> !inj_start_bit);

   // R7
   reg_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !set_v[FLG_REOC] |=> $stable(reg_data));

   // R10
   reg_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_start_bit) |-> flags[FLG_REOC]);

   // R8
   reoc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[FLG_REOC] && !flag_clr[FLG_REOC]) |=> flags[FLG_REOC]);

endmodule

// File: tb/tb_adc_seq_timer.sv
module tb_adc_seq_timer;

   localparam int NCH = 8, CH_W = 5, RD = 4, ID = 2, DW = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [3*NCH-1:0] smp_code = '0;
   logic [RD*CH_W-1:0] reg_list = '0;
   logic [1:0]     reg_len = '0;
   logic [ID*CH_W-1:0] inj_list = '0;
   logic [0:0]     inj_len = '0;
   logic           reg_sw_start = 0, inj_sw_start = 0;
   logic           reg_trig = 0, inj_trig = 0, reg_trig_en = 0, inj_trig_en = 0;
   logic [2:0]     flag_clr = '0, irq_en = '0;
   logic           reg_start_bit, inj_start_bit, irq;
   logic [2:0]     flags;
   logic [DW-1:0]  reg_data, inj_data;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   adc_seq_timer #(.NCH(NCH), .CH_W(CH_W), .REG_DEPTH(RD), .INJ_DEPTH(ID),
                   .DATA_W(DW), .TRIG_EDGE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .smp_code(smp_code), .reg_list(reg_list),
      .reg_len(reg_len), .inj_list(inj_list), .inj_len(inj_len),
      .reg_sw_start(reg_sw_start), .inj_sw_start(inj_sw_start),
      .reg_trig(reg_trig), .inj_trig(inj_trig), .reg_trig_en(reg_trig_en),
      .inj_trig_en(inj_trig_en), .flag_clr(flag_clr), .irq_en(irq_en),
      .reg_start_bit(reg_start_bit), .inj_start_bit(inj_start_bit),
      .flags(flags), .irq(irq), .reg_data(reg_data), .inj_data(inj_data));

   function automatic logic [31:0] half_ticks(input int code);
      case (code)
         0: return 5;    1: return 13;   2: return 25;   3: return 49;
         4: return 95;   5: return 185;  6: return 495;  default: return 1281;
      endcase
   endfunction

   function automatic logic [31:0] exp_res(input int ch);
      logic [15:0] p;
      p = 16'(ch) * 16'h0421;
      return {16'h0, p ^ 16'h5A00};
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic clr_all();
      @(negedge clk) flag_clr = 3'b111;
      @(negedge clk) flag_clr = 3'b000;
   endtask

   task automatic pulse_reg();
      @(negedge clk) reg_sw_start = 1'b1;
      @(negedge clk) reg_sw_start = 1'b0;
   endtask

   task automatic pulse_inj();
      @(negedge clk) inj_sw_start = 1'b1;
      @(negedge clk) inj_sw_start = 1'b0;
   endtask

   task automatic wait_idle();
      int g = 0;
      while ((reg_start_bit || inj_start_bit) && g < 3000) begin
         @(negedge clk);
         g++;
      end
   endtask

   // R12
   task automatic t_reset();
      chk("R12 flags", 32'(flags), 0);
      chk("R12 start bits", {30'h0, reg_start_bit, inj_start_bit}, 0);
      chk("R12 irq", 32'(irq), 0);
      chk("R12 reg_data", 32'(reg_data), 0);
      chk("R12 inj_data", 32'(inj_data), 0);
   endtask

   // R1 R2: every sampling code measured on channel 3
   task automatic t_codes();
      for (int c = 0; c < 8; c++) begin
         int n = 0, smp_at = -1, eoc_at = -1;
         smp_code = '0;
         smp_code[9 +: 3] = 3'(c);
         reg_list[0 +: CH_W] = 5'd3;
         reg_len = 2'd0;
         clr_all();
         pulse_reg();
         while (n < 1400 && eoc_at < 0) begin
            @(negedge clk);
            n++;
            if (smp_at < 0 && flags[0]) smp_at = n;
            if (flags[1]) eoc_at = n;
         end
         chk($sformatf("R1 code %0d", c), 32'(smp_at), half_ticks(c));
         chk($sformatf("R2 code %0d", c), 32'(eoc_at), half_ticks(c) + 25);
         chk("R7 reg_data", 32'(reg_data), exp_res(3));
         chk("R10 start bit cleared", 32'(reg_start_bit), 0);
      end
      smp_code = '0;
      clr_all();
   endtask

   // R4: four entries in order, then stop
   task automatic t_sequence();
      int order [4] = '{5, 1, 7, 2};
      int k = 0;
      for (int i = 0; i < 4; i++) reg_list[i*CH_W +: CH_W] = 5'(order[i]);
      reg_len = 2'd3;
      pulse_reg();
      chk("R10 start bit set", 32'(reg_start_bit), 1);
      for (int n = 0; n < 300; n++) begin
         @(negedge clk);
         flag_clr = 3'b000;
         if (flags[1]) begin
            if (k < 4) chk($sformatf("R4 entry %0d", k), 32'(reg_data), exp_res(order[k]));
            k++;
            flag_clr = 3'b011;
         end
      end
      flag_clr = 3'b000;
      chk("R4 conversion count", 32'(k), 4);
      chk("R4 stopped", 32'(reg_start_bit), 0);
      reg_len = 2'd0;
      clr_all();
   endtask

   // R3 R7: injected list
   task automatic t_injected();
      logic [DW-1:0] keep;
      int j = 0;
      bit smp_seen = 1'b0;
      keep = reg_data;
      inj_list = {5'd4, 5'd6};
      inj_len = 1'b1;
      clr_all();
      pulse_inj();
      chk("R10 inj start bit", 32'(inj_start_bit), 1);
      for (int n = 0; n < 200; n++) begin
         @(negedge clk);
         flag_clr = 3'b000;
         if (flags[0]) smp_seen = 1'b1;
         if (flags[2]) begin
            j++;
            flag_clr = 3'b100;
         end
      end
      flag_clr = 3'b000;
      chk("R3 no end-of-sampling", 32'(smp_seen), 0);
      chk("R4 injected count", 32'(j), 2);
      chk("R7 inj_data", 32'(inj_data), exp_res(4));
      chk("R7 reg_data kept", 32'(reg_data), 32'(keep));
   endtask

   // R6: starts during a long regular run
   task automatic t_ignored();
      logic [DW-1:0] keep;
      int g = 0, cnt = 0;
      bit inj_seen = 1'b0;
      keep = inj_data;
      smp_code[6 +: 3] = 3'd7;
      reg_list[0 +: CH_W] = 5'd2;
      reg_len = 2'd0;
      inj_trig_en = 1'b1;
      clr_all();
      pulse_reg();
      while (g < 2000 && (reg_start_bit || g < 102)) begin
         @(negedge clk);
         g++;
         flag_clr = 3'b000;
         if (g == 100) begin
            reg_sw_start = 1'b1; inj_sw_start = 1'b1; inj_trig = 1'b1;
         end
         if (g == 101) begin
            reg_sw_start = 1'b0; inj_sw_start = 1'b0;
         end
         if (inj_start_bit) inj_seen = 1'b1;
         if (flags[1]) begin
            cnt++;
            flag_clr = 3'b010;
         end
      end
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         flag_clr = 3'b000;
         if (inj_start_bit) inj_seen = 1'b1;
         if (flags[1]) begin
            cnt++;
            flag_clr = 3'b010;
         end
      end
      flag_clr = 3'b000;
      chk("R6 injected never ran", 32'(inj_seen), 0);
      chk("R6 injected flag", 32'(flags[2]), 0);
      chk("R6 inj_data kept", 32'(inj_data), 32'(keep));
      chk("R6 one regular conversion", 32'(cnt), 1);
      chk("R6 regular not restarted", 32'(reg_start_bit), 0);
      inj_trig = 1'b0;
      inj_trig_en = 1'b0;
      smp_code = '0;
      clr_all();
   endtask

   // R5: simultaneous starts
   task automatic t_priority();
      @(negedge clk);
      reg_sw_start = 1'b1; inj_sw_start = 1'b1;
      @(negedge clk);
      reg_sw_start = 1'b0; inj_sw_start = 1'b0;
      chk("R5 injected wins", 32'(inj_start_bit), 1);
      chk("R5 regular held off", 32'(reg_start_bit), 0);
      wait_idle();
      repeat (5) @(negedge clk);
      chk("R5 regular dropped", 32'(reg_start_bit), 0);
      clr_all();
   endtask

   // R5 R11: external triggers
   task automatic t_ext();
      reg_trig_en = 1'b0;
      @(negedge clk) reg_trig = 1'b1;
      repeat (5) @(negedge clk);
      chk("R11 disabled trigger", 32'(reg_start_bit), 0);
      reg_trig = 1'b0;
      reg_trig_en = 1'b1;
      @(negedge clk) reg_trig = 1'b1;
      @(negedge clk);
      chk("R5 regular trigger", 32'(reg_start_bit), 1);
      wait_idle();
      repeat (40) @(negedge clk);
      chk("R11 held trigger once", 32'(reg_start_bit), 0);
      reg_trig = 1'b0;
      reg_trig_en = 1'b0;
      inj_trig_en = 1'b1;
      @(negedge clk) inj_trig = 1'b1;
      @(negedge clk);
      chk("R5 injected trigger", 32'(inj_start_bit), 1);
      inj_trig = 1'b0;
      inj_trig_en = 1'b0;
      wait_idle();
      clr_all();
   endtask

   // R8 R9: sticky flags, collision, interrupt
   task automatic t_flags();
      reg_list[0 +: CH_W] = 5'd3;
      reg_len = 2'd0;
      irq_en = 3'b000;
      clr_all();
      pulse_reg();
      for (int n = 1; n <= 29; n++) @(negedge clk);
      chk("R9 disabled irq", 32'(irq), 0);
      flag_clr = 3'b010;
      @(negedge clk);
      flag_clr = 3'b000;
      chk("R8 set wins over clear", 32'(flags[1]), 1);
      irq_en = 3'b010;
      @(negedge clk);
      chk("R9 enabled irq", 32'(irq), 1);
      repeat (10) @(negedge clk);
      chk("R8 sticky", 32'(flags[1]), 1);
      flag_clr = 3'b010;
      @(negedge clk);
      flag_clr = 3'b000;
      chk("R8 cleared", 32'(flags[1]), 0);
      chk("R8 other bit kept", 32'(flags[0]), 1);
      chk("R9 irq drop", 32'(irq), 0);
      irq_en = 3'b001;
      @(negedge clk);
      chk("R9 sampling irq", 32'(irq), 1);
      irq_en = 3'b000;
      clr_all();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_codes();
      t_sequence();
      t_injected();
      t_ignored();
      t_priority();
      t_ext();
      t_flags();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule